// File: doc/BRIEF.md
# Saturating Narrow-Interleave Vector Unit

This unit turns a pair of vectors of signed 32-bit elements into one vector of signed 16-bit elements. Any element that falls outside the signed 16-bit range is clamped to the nearest limit. The narrowed results from the two sources are then woven together, one element from each source in turn. The vector width is set at build time and must be a multiple of 32 bits.

A small front end sits beside the datapath. It recognises the one fixed 32-bit instruction word that selects this operation. It reports the destination register index and the aligned pair of source register indices. It also raises an undefined-instruction flag when both feature-enable inputs are low.

The result is registered. A small control machine has two states:
- `ST_IDLE`: no result is presented.
- `ST_OUT`: a fresh result is on the outputs for one cycle.

It has two transitions:
- **accept**: `valid_in` is high and the word is recognised and defined. The machine moves to `ST_OUT`, and the result and flags are captured.
- **drain**: any other cycle. The machine returns to `ST_IDLE`, and the captured data holds.

Top module: `narrow_ilv_unit`

## Requirements
- R1: A source element greater than 32767 produces 0x7FFF in its destination element.
- R2: A source element less than -32768 produces 0x8000 in its destination element.
- R3: A source element in the range -32768..32767 produces its own low 16 bits, unchanged.
- R4: Source element e occupies bits [e*32 +: 32]. Destination element k occupies bits [k*16 +: 16]. Destination element 2e+i comes from element e of source i (`src0_i` is i=0, `src1_i` is i=1). Every destination element is written on each accepted operation.
- R5: Bit k of `sat_o` is 1 exactly when destination element k was clamped.
- R6: `match_o` is 1 exactly when instruction bits 31..10 equal 0100010100110001010000 and bit 5 is 0.
- R7: Instruction bits 4..0 give `dst_idx_o`. With S taken from bits 9..6, `src_a_idx_o` is 2*S and `src_b_idx_o` is 2*S+1.
- R8: `undef_o` is 1 when `match_o` is 1 and both `feat_a_i` and `feat_b_i` are 0. Such an instruction produces no result: `valid_o` stays 0 and `dst_o` is unchanged.
- R9: An accepted operation (`valid_in` high, `match_o` high, `undef_o` low) raises `valid_o` on the next cycle with its result. In every other cycle, `valid_o` is 0 on the following cycle.
- R10: After reset, `valid_o`, `dst_o` and `sat_o` are 0. `dst_o` and `sat_o` change only in the cycle after an accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operation request |
| insn_i | input | 32 | Instruction word |
| feat_a_i | input | 1 | First feature enable |
| feat_b_i | input | 1 | Second feature enable |
| src0_i | input | VL | First source vector (32-bit elements) |
| src1_i | input | VL | Second source vector (32-bit elements) |
| match_o | output | 1 | Instruction word recognised |
| undef_o | output | 1 | Recognised but undefined |
| dst_idx_o | output | 5 | Destination register index |
| src_a_idx_o | output | 5 | First source register index |
| src_b_idx_o | output | 5 | Second source register index |
| valid_o | output | 1 | Result valid |
| dst_o | output | VL | Narrowed, interleaved result |
| sat_o | output | VL/16 | Per-destination-element clamp flags |

## Verification
The bench builds two copies of the unit, one with VL=128 and one with VL=256. Both are driven from the same 256-bit stimulus, so the narrower copy is checked against the low half of the same expected result. With 128 bits, one directed vector can place all six range-edge values, plus zero and -1, into distinct element positions. This covers each clamping direction and the interleave order. The 256-bit copy carries random operands biased toward the 16-bit boundary, across a larger set of element pairs. Decode is checked on recognised words with each feature combination and on words with single-bit corruptions.

// File: rtl/nilv_pkg.sv
package nilv_pkg;
    localparam int unsigned SRC_W = 32;
    localparam int unsigned DST_W = 16;
    localparam int unsigned IDX_W = 5;
    localparam logic [21:0] OPC_HI = 22'b0100010100110001010000;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } nilv_state_e;
endpackage

// File: rtl/nilv_decode.sv
module nilv_decode
    import nilv_pkg::*;
(
    input  logic [31:0]      insn_i,
    input  logic             feat_a_i,
    input  logic             feat_b_i,
    output logic             match_o,
    output logic             undef_o,
    output logic [IDX_W-1:0] dst_idx_o,
    output logic [IDX_W-1:0] src_a_idx_o,
    output logic [IDX_W-1:0] src_b_idx_o
);
    logic [3:0] pair_f;

    always_comb begin
        pair_f      = insn_i[9:6];
        match_o     = (insn_i[31:10] == OPC_HI) && !insn_i[5];
        undef_o     = match_o && !(feat_a_i || feat_b_i);
        dst_idx_o   = insn_i[4:0];
        src_a_idx_o = {pair_f, 1'b0};
        src_b_idx_o = {pair_f, 1'b1};
    end
endmodule

// File: rtl/nilv_sat_lane.sv
module nilv_sat_lane
    import nilv_pkg::*;
(
    input  logic [SRC_W-1:0] val_i,
    output logic [DST_W-1:0] val_o,
    output logic             sat_o
);
    localparam logic [DST_W-1:0] POS_LIM = {1'b0, {(DST_W-1){1'b1}}};
    localparam logic [DST_W-1:0] NEG_LIM = {1'b1, {(DST_W-1){1'b0}}};

    logic [SRC_W-DST_W:0] top_bits;
    logic                 fits;

    always_comb begin
        top_bits = val_i[SRC_W-1:DST_W-1];
        fits     = (&top_bits) || !(|top_bits);
        sat_o    = !fits;
        if (fits)
            val_o = val_i[DST_W-1:0];
        else if (val_i[SRC_W-1])
            val_o = NEG_LIM;
        else
            val_o = POS_LIM;
    end

    always_comb begin
        // R1
        sat_extreme_chk: assert (!sat_o || val_o == POS_LIM || val_o == NEG_LIM);
        // R3
        pass_through_chk: assert (sat_o || $signed(val_o) == $signed(val_i));
    end
endmodule

// File: rtl/narrow_ilv_unit.sv
module narrow_ilv_unit
    import nilv_pkg::*;
#(
    parameter int unsigned VL = 128
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [31:0]      insn_i,
    input  logic             feat_a_i,
    input  logic             feat_b_i,
    input  logic [VL-1:0]    src0_i,
    input  logic [VL-1:0]    src1_i,
    output logic             match_o,
    output logic             undef_o,
    output logic [4:0]       dst_idx_o,
    output logic [4:0]       src_a_idx_o,
    output logic [4:0]       src_b_idx_o,
    output logic             valid_o,
    output logic [VL-1:0]    dst_o,
    output logic [VL/16-1:0] sat_o
);
    localparam int unsigned N_PAIR = VL / SRC_W;
    localparam int unsigned N_DST  = VL / DST_W;

    initial begin
        vl_param_chk: assert (VL % 32 == 0 && VL >= 128 && VL <= 2048);
    end

    nilv_state_e      state_q, state_d;
    logic             accept;
    logic [VL-1:0]    nar_w;
    logic [N_DST-1:0] sat_w;
    logic [VL-1:0]    dst_q;
    logic [N_DST-1:0] sat_q;

    nilv_decode u_dec (
        .insn_i      (insn_i),
        .feat_a_i    (feat_a_i),
        .feat_b_i    (feat_b_i),
        .match_o     (match_o),
        .undef_o     (undef_o),
        .dst_idx_o   (dst_idx_o),
        .src_a_idx_o (src_a_idx_o),
        .src_b_idx_o (src_b_idx_o)
    );

    for (genvar e = 0; e < N_PAIR; e++) begin : g_pair
        nilv_sat_lane u_l0 (
            .val_i (src0_i[e*SRC_W +: SRC_W]),
            .val_o (nar_w[(2*e)*DST_W +: DST_W]),
            .sat_o (sat_w[2*e])
        );
        nilv_sat_lane u_l1 (
            .val_i (src1_i[e*SRC_W +: SRC_W]),
            .val_o (nar_w[(2*e+1)*DST_W +: DST_W]),
            .sat_o (sat_w[2*e+1])
        );
    end

    assign accept = valid_in && match_o && !undef_o;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = accept ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dst_q   <= '0;
            sat_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dst_q <= nar_w;
                sat_q <= sat_w;
            end
        end
    end

    always_comb begin
        valid_o = (state_q == ST_OUT);
        dst_o   = dst_q;
        sat_o   = sat_q;
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(valid_in && match_o && !undef_o));
    // R8
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && undef_o) |=> !valid_o);
    // R10
    hold_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(dst_o) && $stable(sat_o)));
endmodule

// File: tb/sim_narrow_ilv_unit.sv
module sim_narrow_ilv_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         valid_in = 1'b0;
    logic [31:0]  insn = '0;
    logic         fa = 1'b1, fb = 1'b0;
    logic [255:0] s0 = '0, s1 = '0;

    logic        m0, u0f, v0, m1, u1f, v1;
    logic [4:0]  d0, a0, b0, d1, a1, b1;
    logic [127:0] o0;
    logic [7:0]   f0;
    logic [255:0] o1;
    logic [15:0]  f1;

    int n_run = 0, n_fail = 0;

    narrow_ilv_unit #(.VL(128)) u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .insn_i(insn),
        .feat_a_i(fa), .feat_b_i(fb), .src0_i(s0[127:0]), .src1_i(s1[127:0]),
        .match_o(m0), .undef_o(u0f), .dst_idx_o(d0), .src_a_idx_o(a0),
        .src_b_idx_o(b0), .valid_o(v0), .dst_o(o0), .sat_o(f0));

    narrow_ilv_unit #(.VL(256)) u1 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .insn_i(insn),
        .feat_a_i(fa), .feat_b_i(fb), .src0_i(s0), .src1_i(s1),
        .match_o(m1), .undef_o(u1f), .dst_idx_o(d1), .src_a_idx_o(a1),
        .src_b_idx_o(b1), .valid_o(v1), .dst_o(o1), .sat_o(f1));

    function automatic logic [16:0] sat_ref(logic [31:0] x);
        int signed sx = $signed(x);
        if (sx > 32767)  return {1'b1, 16'h7FFF};
        if (sx < -32768) return {1'b1, 16'h8000};
        return {1'b0, x[15:0]};
    endfunction

    logic [255:0] exp_d;
    logic [15:0]  exp_f;

    task automatic compute_exp();
        for (int e = 0; e < 8; e++) begin
            logic [16:0] r0 = sat_ref(s0[e*32 +: 32]);
            logic [16:0] r1 = sat_ref(s1[e*32 +: 32]);
            exp_d[(2*e)*16 +: 16]   = r0[15:0];
            exp_d[(2*e+1)*16 +: 16] = r1[15:0];
            exp_f[2*e]   = r0[16];
            exp_f[2*e+1] = r1[16];
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(logic [3:0] zn, logic [4:0] zd);
        return {22'b0100010100110001010000, zn, 1'b0, zd};
    endfunction

    function automatic logic [31:0] biased();
        logic [31:0] r = $urandom;
        unique case ($urandom % 4)
            0: return r;
            1: return {{16{r[15]}}, r[15:0]};
            2: return {{15{r[16]}}, r[16:0]};
            default: return r[0] ? 32'h0000_8000 : 32'hFFFF_7FFF;
        endcase
    endfunction

    // drive at negedge, run one operation, sample at the following negedge
    task automatic run_op(input bit v);
        @(negedge clk);
        valid_in = v;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!v0 && !v1 && o0 == 0 && o1 == 0 && f0 == 0 && f1 == 0,
              "R10", "reset outputs", {o1}, 256'h0);

        // R6 / R7 decode of a recognised word
        insn = mk_insn(4'd13, 5'd22);
        #1;
        check(m0 && m1, "R6", "match", {255'h0, m0}, 256'h1);
        check(d0 == 22 && a0 == 26 && b0 == 27 && d1 == 22 && b1 == 27, "R7", "indices",
              {241'h0, d0, a0, b0}, {241'h0, 5'd22, 5'd26, 5'd27});
        insn = mk_insn(4'd0, 5'd31);
        #1;
        check(a0 == 0 && b0 == 1 && d0 == 31, "R7", "indices low pair",
              {241'h0, d0, a0, b0}, {241'h0, 5'd31, 5'd0, 5'd1});
        // R6 bit 5 set, and a corrupted opcode bit
        insn = mk_insn(4'd3, 5'd1) | 32'h20;
        #1;
        check(!m0 && !u0f, "R6", "bit5 set rejected", {255'h0, m0}, 256'h0);
        for (int b = 10; b < 32; b++) begin
            insn = mk_insn(4'd3, 5'd1) ^ (32'h1 << b);
            #1;
            check(!m0 && !m1, "R6", "opcode bit flip", {224'h0, insn}, 256'h0);
        end
        // R8 undef decode under each feature combination
        insn = mk_insn(4'd1, 5'd2);
        for (int k = 0; k < 4; k++) begin
            fa = k[0]; fb = k[1];
            #1;
            check(u0f == (k == 0) && u1f == (k == 0), "R8", "undef flag",
                  {255'h0, u0f}, {255'h0, (k == 0)});
        end

        // R1 R2 R3 R4 R5 directed edge vector
        fa = 1'b0; fb = 1'b1;
        s0 = '0; s1 = '0;
        s0[31:0]   = 32'h0000_7FFF;  s1[31:0]   = 32'hFFFF_8000;
        s0[63:32]  = 32'h0000_8000;  s1[63:32]  = 32'hFFFF_7FFF;
        s0[95:64]  = 32'h7FFF_FFFF;  s1[95:64]  = 32'h8000_0000;
        s0[127:96] = 32'h0000_0000;  s1[127:96] = 32'hFFFF_FFFF;
        run_op(1'b1);
        check(v0 && v1, "R9", "valid after accept", {255'h0, v0}, 256'h1);
        check(o0[15:0] == 16'h7FFF && o0[31:16] == 16'h8000, "R3", "limits pass",
              {128'h0, o0}, 256'h0);
        check(o0[47:32] == 16'h7FFF && o0[79:64] == 16'h7FFF, "R1", "clamp high",
              {128'h0, o0}, 256'h0);
        check(o0[63:48] == 16'h8000 && o0[95:80] == 16'h8000, "R2", "clamp low",
              {128'h0, o0}, 256'h0);
        check(o0[127:96] == 32'hFFFF_0000, "R4", "interleave order",
              {128'h0, o0}, {224'h0, 32'hFFFF_0000});
        check(f0 == 8'b0011_1100, "R5", "sat flags", {248'h0, f0}, {248'h0, 8'b0011_1100});
        @(negedge clk);
        check(!v0 && o0[15:0] == 16'h7FFF, "R10", "hold after drain", {128'h0, o0}, 256'h0);

        // R8 undefined: no result, output held
        fa = 1'b0; fb = 1'b0;
        s0 = '1; s1 = '1;
        run_op(1'b1);
        check(!v0 && !v1 && o0[15:0] == 16'h7FFF, "R8", "undef no result",
              {128'h0, o0}, 256'h0);
        // R9 non-matching word with valid gives nothing
        fa = 1'b1;
        insn = mk_insn(4'd1, 5'd2) | 32'h20;
        run_op(1'b1);
        check(!v0 && !v1 && o0[15:0] == 16'h7FFF, "R9", "nonmatch no result",
              {128'h0, o0}, 256'h0);
        insn = mk_insn(4'd1, 5'd2);

        // R4 R5 random sweep against both widths
        for (int t = 0; t < 400; t++) begin
            for (int e = 0; e < 8; e++) begin
                s0[e*32 +: 32] = biased();
                s1[e*32 +: 32] = biased();
            end
            compute_exp();
            run_op(1'b1);
            check(v1 && o1 == exp_d && f1 == exp_f, "R4", "random VL256", o1, exp_d);
            check(v0 && o0 == exp_d[127:0] && f0 == exp_f[7:0], "R5", "random VL128",
                  {128'h0, o0}, {128'h0, exp_d[127:0]});
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule